// File: doc/BRIEF.md
# USB Device Token Sequencer

This block handles the device side of full-speed USB token traffic for up to sixteen endpoints. A packet receiver hands it decoded tokens: the packet ID, the device address and the endpoint number. The block compares each token with the configured device address and with the per-endpoint enable. For an IN token it asks a packet transmitter to send either the buffered data packet or a NAK. After a data packet it waits for the host ACK, except on isochronous endpoints. When the transfer completes, it clears the endpoint's buffer-full bit, flips its data toggle and raises the endpoint's interrupt bit.

For an OUT token it waits for the host's data packet. It takes the data only into an empty buffer and then answers with ACK; a full buffer gets a NAK. Isochronous OUT transfers get no handshake. A microprocessor fills or drains buffers through a buffer-write strobe. It reads the interrupt vector through a read strobe, and that strobe clears the vector.

Top module: `usb_token_seq`

## Requirements
- R1: After reset the interrupt vector, every buffer-full bit, every toggle bit and the transmit request are all zero.
- R2: A token is ignored, with no transmit request, if its address differs from the device address, its endpoint is disabled, or its PID is neither IN (4'b1001) nor OUT (4'b0001).
- R3: An accepted IN token raises a one-cycle transmit request on the next clock. If the buffer is full, the PID is DATA0 (4'b0011) when the toggle is 0 and DATA1 (4'b1011) when it is 1. If the buffer is empty, the PID is NAK (4'b1010).
- R4: On a non-isochronous endpoint, a host ACK (4'b0010) that arrives after the data packet's transmit-done clears the buffer-full bit, sets the endpoint's interrupt bit and flips its toggle, all on the same clock.
- R5: If no handshake arrives within 64 cycles of transmit-done (16 bit times of 4 clocks), the sequencer returns to idle. Buffer-full stays set, no interrupt is raised, a late ACK is ignored, and the next IN resends with the same data PID.
- R6: On an isochronous endpoint the data PID is always DATA0. Transmit-done alone clears buffer-full and sets the interrupt bit, and the toggle is left unchanged.
- R7: A read strobe clears the interrupt vector. A bit set on the same clock is kept, and the interrupt output is high while any bit is set.
- R8: After an accepted OUT token, the received data packet is answered with ACK on an empty buffer, which also sets buffer-full, the interrupt bit and flips the toggle. A full buffer gets a NAK and no change. An isochronous endpoint gets no handshake.
- R9: Tokens that arrive while a transaction is in progress are ignored.
- R10: A processor buffer write sets or clears the buffer-full bit of the selected endpoint only.
- R11: If the OUT data packet does not arrive within 64 cycles, the sequencer returns to idle, and a later data packet is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_addr_i | input | 7 | Configured device address |
| ep_en_i | input | 16 | Per-endpoint enable |
| ep_iso_i | input | 16 | Per-endpoint isochronous type |
| tok_valid_i | input | 1 | Token strobe |
| tok_pid_i | input | 4 | Token PID |
| tok_addr_i | input | 7 | Token device address |
| tok_ep_i | input | 4 | Token endpoint number |
| tx_done_i | input | 1 | Transmitter finished the requested packet |
| hs_valid_i | input | 1 | Handshake packet received from host |
| hs_pid_i | input | 4 | Received handshake PID |
| rx_done_i | input | 1 | OUT data packet fully received |
| cpu_irq_rd_i | input | 1 | Interrupt vector read strobe (clears) |
| cpu_buf_we_i | input | 1 | Buffer status write strobe |
| cpu_buf_ep_i | input | 4 | Endpoint for buffer write |
| cpu_buf_full_i | input | 1 | Buffer-full value to write |
| tx_req_o | output | 1 | Transmit request pulse |
| tx_pid_o | output | 4 | PID of packet to transmit |
| irq_o | output | 1 | Interrupt, high while any bit is set |
| irq_bits_o | output | 16 | Interrupt vector, one bit per endpoint |
| ep_full_o | output | 16 | Buffer-full bits |
| ep_tog_o | output | 16 | Data toggle bits |

## Verification
Every result is registered once. A token, transmit-done, handshake, data-received or processor strobe that is applied before a rising edge shows its effect on the ports right after that edge, and the transmit request drops again one clock later. The bench drives each stimulus on a falling edge for one cycle and samples on the next falling edge, so it reads each result in the first cycle it is due. The timeout checks wait past the 64-cycle window before they send the late handshake or data packet.

// File: rtl/usb_seq_pkg.sv
package usb_seq_pkg;
  localparam logic [3:0] PID_OUT   = 4'b0001;
  localparam logic [3:0] PID_IN    = 4'b1001;
  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;
  localparam logic [3:0] PID_ACK   = 4'b0010;
  localparam logic [3:0] PID_NAK   = 4'b1010;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_ACK_WAIT,
    ST_OUT_WAIT
  } seq_state_e;
endpackage

// File: rtl/tok_match.sv
module tok_match #(
  parameter int N_EP   = 16,
  parameter int ADDR_W = 7,
  localparam int EP_W  = $clog2(N_EP)
) (
  input  logic              tok_valid_i,
  input  logic [3:0]        tok_pid_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [N_EP-1:0]   ep_en_i,
  output logic              in_hit_o,
  output logic              out_hit_o
);
  import usb_seq_pkg::*;

  logic target_ok;

  always_comb begin
    target_ok = tok_valid_i && (tok_addr_i == dev_addr_i) && ep_en_i[tok_ep_i];
    in_hit_o  = target_ok && (tok_pid_i == PID_IN);
    out_hit_o = target_ok && (tok_pid_i == PID_OUT);
  end
endmodule

// File: rtl/ep_status.sv
module ep_status #(
  parameter int N_EP  = 16,
  localparam int EP_W = $clog2(N_EP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EP_W-1:0] ev_ep_i,
  input  logic            ev_set_full_i,
  input  logic            ev_clr_full_i,
  input  logic            ev_flip_i,
  input  logic            cpu_we_i,
  input  logic [EP_W-1:0] cpu_ep_i,
  input  logic            cpu_full_i,
  output logic [N_EP-1:0] full_o,
  output logic [N_EP-1:0] tog_o
);
  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    logic ev_sel, cpu_sel;
    assign ev_sel  = (ev_ep_i == EP_W'(i));
    assign cpu_sel = cpu_we_i && (cpu_ep_i == EP_W'(i));

    // engine events take priority over a same-cycle processor write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_o[i] <= 1'b0;
      end else if (ev_sel && ev_set_full_i) begin
        full_o[i] <= 1'b1;
      end else if (ev_sel && ev_clr_full_i) begin
        full_o[i] <= 1'b0;
      end else if (cpu_sel) begin
        full_o[i] <= cpu_full_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tog_o[i] <= 1'b0;
      end else if (ev_sel && ev_flip_i) begin
        tog_o[i] <= ~tog_o[i];
      end
    end
  end
endmodule

// File: rtl/irq_vec.sv
module irq_vec #(
  parameter int N_EP = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_EP-1:0] set_i,
  input  logic            rd_clr_i,
  output logic [N_EP-1:0] bits_o,
  output logic            any_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_o <= '0;
    end else begin
      bits_o <= (rd_clr_i ? '0 : bits_o) | set_i;
    end
  end

  assign any_o = |bits_o;
endmodule

// File: rtl/txn_fsm.sv
module txn_fsm #(
  parameter int N_EP     = 16,
  parameter int BIT_CLKS = 4,
  parameter int TO_BITS  = 16,
  localparam int EP_W    = $clog2(N_EP),
  localparam int TO_CYC  = BIT_CLKS * TO_BITS,
  localparam int CNT_W   = $clog2(TO_CYC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_hit_i,
  input  logic                     out_hit_i,
  input  logic [EP_W-1:0]          tok_ep_i,
  input  logic [N_EP-1:0]          ep_full_i,
  input  logic [N_EP-1:0]          ep_tog_i,
  input  logic [N_EP-1:0]          ep_iso_i,
  input  logic                     tx_done_i,
  input  logic                     hs_valid_i,
  input  logic [3:0]               hs_pid_i,
  input  logic                     rx_done_i,
  output logic                     tx_req_o,
  output logic [3:0]               tx_pid_o,
  output logic [EP_W-1:0]          ev_ep_o,
  output logic                     ev_set_full_o,
  output logic                     ev_clr_full_o,
  output logic                     ev_flip_o,
  output logic                     ev_irq_o,
  output usb_seq_pkg::seq_state_e  st_o,
  output logic                     cur_iso_o
);
  import usb_seq_pkg::*;

  seq_state_e       st_q, st_d;
  logic [EP_W-1:0]  ep_q, ep_d;
  logic             iso_q, iso_d;
  logic             data_q, data_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic [3:0]       pid_q, pid_d;
  logic             cnt_end;

  assign cnt_end = (cnt_q == CNT_W'(TO_CYC - 1));

  always_comb begin
    st_d          = st_q;
    ep_d          = ep_q;
    iso_d         = iso_q;
    data_d        = data_q;
    cnt_d         = cnt_q;
    req_d         = 1'b0;
    pid_d         = pid_q;
    ev_set_full_o = 1'b0;
    ev_clr_full_o = 1'b0;
    ev_flip_o     = 1'b0;
    ev_irq_o      = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (in_hit_i) begin
          ep_d   = tok_ep_i;
          iso_d  = ep_iso_i[tok_ep_i];
          req_d  = 1'b1;
          data_d = ep_full_i[tok_ep_i];
          if (!ep_full_i[tok_ep_i]) begin
            pid_d = PID_NAK;
          end else if (ep_iso_i[tok_ep_i] || !ep_tog_i[tok_ep_i]) begin
            pid_d = PID_DATA0;
          end else begin
            pid_d = PID_DATA1;
          end
          st_d = ST_SEND;
        end else if (out_hit_i) begin
          ep_d  = tok_ep_i;
          iso_d = ep_iso_i[tok_ep_i];
          cnt_d = '0;
          st_d  = ST_OUT_WAIT;
        end
      end

      ST_SEND: begin
        if (tx_done_i) begin
          if (data_q && !iso_q) begin
            cnt_d = '0;
            st_d  = ST_ACK_WAIT;
          end else begin
            if (data_q) begin
              // isochronous: done once the packet is on the wire
              ev_clr_full_o = 1'b1;
              ev_irq_o      = 1'b1;
            end
            st_d = ST_IDLE;
          end
        end
      end

      ST_ACK_WAIT: begin
        if (hs_valid_i) begin
          if (hs_pid_i == PID_ACK) begin
            ev_clr_full_o = 1'b1;
            ev_flip_o     = 1'b1;
            ev_irq_o      = 1'b1;
          end
          st_d = ST_IDLE;
        end else if (cnt_end) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      ST_OUT_WAIT: begin
        if (rx_done_i) begin
          if (!ep_full_i[ep_q]) begin
            ev_set_full_o = 1'b1;
            ev_irq_o      = 1'b1;
            ev_flip_o     = !iso_q;
          end
          if (iso_q) begin
            st_d = ST_IDLE;
          end else begin
            req_d  = 1'b1;
            data_d = 1'b0;
            pid_d  = ep_full_i[ep_q] ? PID_NAK : PID_ACK;
            st_d   = ST_SEND;
          end
        end else if (cnt_end) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ep_q   <= '0;
      iso_q  <= 1'b0;
      data_q <= 1'b0;
      cnt_q  <= '0;
      req_q  <= 1'b0;
      pid_q  <= PID_NAK;
    end else begin
      st_q   <= st_d;
      ep_q   <= ep_d;
      iso_q  <= iso_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
      req_q  <= req_d;
      pid_q  <= pid_d;
    end
  end

  assign tx_req_o  = req_q;
  assign tx_pid_o  = pid_q;
  assign ev_ep_o   = ep_q;
  assign st_o      = st_q;
  assign cur_iso_o = iso_q;
endmodule

// File: rtl/usb_token_seq.sv
module usb_token_seq #(
  parameter int N_EP     = 16,
  parameter int ADDR_W   = 7,
  parameter int BIT_CLKS = 4,
  parameter int TO_BITS  = 16,
  localparam int EP_W    = $clog2(N_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [N_EP-1:0]   ep_en_i,
  input  logic [N_EP-1:0]   ep_iso_i,
  input  logic              tok_valid_i,
  input  logic [3:0]        tok_pid_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              tx_done_i,
  input  logic              hs_valid_i,
  input  logic [3:0]        hs_pid_i,
  input  logic              rx_done_i,
  input  logic              cpu_irq_rd_i,
  input  logic              cpu_buf_we_i,
  input  logic [EP_W-1:0]   cpu_buf_ep_i,
  input  logic              cpu_buf_full_i,
  output logic              tx_req_o,
  output logic [3:0]        tx_pid_o,
  output logic              irq_o,
  output logic [N_EP-1:0]   irq_bits_o,
  output logic [N_EP-1:0]   ep_full_o,
  output logic [N_EP-1:0]   ep_tog_o
);
  import usb_seq_pkg::*;

  logic            in_hit, out_hit;
  logic [EP_W-1:0] ev_ep;
  logic            ev_set_full, ev_clr_full, ev_flip, ev_irq;
  logic [N_EP-1:0] irq_set;
  seq_state_e      seq_st;
  logic            cur_iso;

  tok_match #(.N_EP(N_EP), .ADDR_W(ADDR_W)) u_match (
    .tok_valid_i (tok_valid_i),
    .tok_pid_i   (tok_pid_i),
    .tok_addr_i  (tok_addr_i),
    .tok_ep_i    (tok_ep_i),
    .dev_addr_i  (dev_addr_i),
    .ep_en_i     (ep_en_i),
    .in_hit_o    (in_hit),
    .out_hit_o   (out_hit)
  );

  txn_fsm #(.N_EP(N_EP), .BIT_CLKS(BIT_CLKS), .TO_BITS(TO_BITS)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_hit_i      (in_hit),
    .out_hit_i     (out_hit),
    .tok_ep_i      (tok_ep_i),
    .ep_full_i     (ep_full_o),
    .ep_tog_i      (ep_tog_o),
    .ep_iso_i      (ep_iso_i),
    .tx_done_i     (tx_done_i),
    .hs_valid_i    (hs_valid_i),
    .hs_pid_i      (hs_pid_i),
    .rx_done_i     (rx_done_i),
    .tx_req_o      (tx_req_o),
    .tx_pid_o      (tx_pid_o),
    .ev_ep_o       (ev_ep),
    .ev_set_full_o (ev_set_full),
    .ev_clr_full_o (ev_clr_full),
    .ev_flip_o     (ev_flip),
    .ev_irq_o      (ev_irq),
    .st_o          (seq_st),
    .cur_iso_o     (cur_iso)
  );

  ep_status #(.N_EP(N_EP)) u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ev_ep_i       (ev_ep),
    .ev_set_full_i (ev_set_full),
    .ev_clr_full_i (ev_clr_full),
    .ev_flip_i     (ev_flip),
    .cpu_we_i      (cpu_buf_we_i),
    .cpu_ep_i      (cpu_buf_ep_i),
    .cpu_full_i    (cpu_buf_full_i),
    .full_o        (ep_full_o),
    .tog_o         (ep_tog_o)
  );

  assign irq_set = ev_irq ? (N_EP'(1) << ev_ep) : '0;

  irq_vec #(.N_EP(N_EP)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (irq_set),
    .rd_clr_i (cpu_irq_rd_i),
    .bits_o   (irq_bits_o),
    .any_o    (irq_o)
  );
endmodule

// File: rtl/usb_token_seq_chk.sv
module usb_token_seq_chk #(
  parameter int N_EP   = 16,
  parameter int ADDR_W = 7
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tok_valid_i,
  input logic [ADDR_W-1:0]       tok_addr_i,
  input logic [ADDR_W-1:0]       dev_addr_i,
  input logic                    rx_done_i,
  input logic                    hs_valid_i,
  input logic [3:0]              hs_pid_i,
  input logic                    cpu_irq_rd_i,
  input logic                    tx_req_o,
  input logic [3:0]              tx_pid_o,
  input logic                    irq_o,
  input logic [N_EP-1:0]         irq_bits_o,
  input usb_seq_pkg::seq_state_e seq_st,
  input logic                    cur_iso
);
  import usb_seq_pkg::*;

  // R3
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);

  // R3
  tx_pid_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> (tx_pid_o == PID_DATA0 || tx_pid_o == PID_DATA1 ||
                  tx_pid_o == PID_ACK   || tx_pid_o == PID_NAK));

  // R2
  addr_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_addr_i != dev_addr_i && !rx_done_i) |=> !tx_req_o);

  // R4
  ack_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_st == ST_ACK_WAIT && hs_valid_i && hs_pid_i == PID_ACK) |=> irq_o);

  // R6
  iso_data0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && cur_iso) |-> (tx_pid_o != PID_DATA1));

  // R7
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_irq_rd_i && seq_st == ST_IDLE) |=> (irq_bits_o == '0));
endmodule

bind usb_token_seq usb_token_seq_chk #(.N_EP(N_EP), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tok_valid_i  (tok_valid_i),
  .tok_addr_i   (tok_addr_i),
  .dev_addr_i   (dev_addr_i),
  .rx_done_i    (rx_done_i),
  .hs_valid_i   (hs_valid_i),
  .hs_pid_i     (hs_pid_i),
  .cpu_irq_rd_i (cpu_irq_rd_i),
  .tx_req_o     (tx_req_o),
  .tx_pid_o     (tx_pid_o),
  .irq_o        (irq_o),
  .irq_bits_o   (irq_bits_o),
  .seq_st       (seq_st),
  .cur_iso      (cur_iso)
);

// File: tb/usb_token_seq_test.sv
module usb_token_seq_test;
  localparam logic [3:0] P_OUT = 4'b0001, P_IN = 4'b1001, P_SETUP = 4'b1101;
  localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011, P_ACK = 4'b0010, P_NAK = 4'b1010;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int TO = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] ep_en = 16'hFFDF, ep_iso = 16'h0008;
  logic        tok_v = 0, tx_done = 0, hs_v = 0, rx_done = 0;
  logic        irq_rd = 0, buf_we = 0, buf_full = 0;
  logic [3:0]  tok_pid = 0, tok_ep = 0, hs_pid = 0, buf_ep = 0;
  logic [6:0]  tok_addr = 0;
  logic        tx_req, irq;
  logic [3:0]  tx_pid;
  logic [15:0] irq_bits, full, tog;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  usb_token_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(ADDR), .ep_en_i(ep_en), .ep_iso_i(ep_iso),
    .tok_valid_i(tok_v), .tok_pid_i(tok_pid), .tok_addr_i(tok_addr), .tok_ep_i(tok_ep),
    .tx_done_i(tx_done), .hs_valid_i(hs_v), .hs_pid_i(hs_pid), .rx_done_i(rx_done),
    .cpu_irq_rd_i(irq_rd), .cpu_buf_we_i(buf_we), .cpu_buf_ep_i(buf_ep),
    .cpu_buf_full_i(buf_full), .tx_req_o(tx_req), .tx_pid_o(tx_pid), .irq_o(irq),
    .irq_bits_o(irq_bits), .ep_full_o(full), .ep_tog_o(tog)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tok(input logic [3:0] pid, input logic [6:0] a, input logic [3:0] ep);
    tok_pid = pid; tok_addr = a; tok_ep = ep; tok_v = 1;
    @(negedge clk); tok_v = 0;
  endtask

  task automatic done_tx();
    tx_done = 1; @(negedge clk); tx_done = 0;
  endtask

  task automatic hs(input logic [3:0] pid);
    hs_pid = pid; hs_v = 1; @(negedge clk); hs_v = 0;
  endtask

  task automatic rx();
    rx_done = 1; @(negedge clk); rx_done = 0;
  endtask

  task automatic rd_irq();
    irq_rd = 1; @(negedge clk); irq_rd = 0;
  endtask

  task automatic wbuf(input logic [3:0] ep, input logic v);
    buf_ep = ep; buf_full = v; buf_we = 1; @(negedge clk); buf_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {16'h0, irq_bits}, 0);
    chk("R1 full", {16'h0, full}, 0);
    chk("R1 tog", {16'h0, tog}, 0);
    chk("R1 tx_req", {31'h0, tx_req}, 0);
  endtask

  task automatic t_ignore();
    wbuf(1, 1);
    tok(P_IN, 7'h2B, 1); chk("R2 addr", {31'h0, tx_req}, 0);
    tok(P_IN, ADDR, 5);  chk("R2 disabled", {31'h0, tx_req}, 0);
    tok(P_SETUP, ADDR, 1); chk("R2 pid", {31'h0, tx_req}, 0);
    idle(2); chk("R2 still none", {31'h0, tx_req}, 0);
  endtask

  task automatic t_in_nak();
    tok(P_IN, ADDR, 2);
    chk("R3 nak req", {31'h0, tx_req}, 1);
    chk("R3 nak pid", {28'h0, tx_pid}, P_NAK);
    @(negedge clk); chk("R3 pulse", {31'h0, tx_req}, 0);
    done_tx();
    chk("R3 nak no irq", {16'h0, irq_bits}, 0);
  endtask

  task automatic t_in_ack();
    tok(P_IN, ADDR, 1);
    chk("R3 data req", {31'h0, tx_req}, 1);
    chk("R3 data0", {28'h0, tx_pid}, P_D0);
    done_tx();
    // R9: busy while waiting for ACK
    wbuf(2, 1);
    tok(P_IN, ADDR, 2); chk("R9 busy ignore", {31'h0, tx_req}, 0);
    hs(P_ACK);
    chk("R4 full clr", {31'h0, full[1]}, 0);
    chk("R4 irq bit", {16'h0, irq_bits}, 16'h0002);
    chk("R4 toggle", {31'h0, tog[1]}, 1);
    chk("R7 irq out", {31'h0, irq}, 1);
    rd_irq();
    chk("R7 clear", {16'h0, irq_bits}, 0);
    chk("R7 irq low", {31'h0, irq}, 0);
    wbuf(1, 1);
    tok(P_IN, ADDR, 1);
    chk("R3 data1", {28'h0, tx_pid}, P_D1);
    done_tx(); hs(P_ACK);
    chk("R4 toggle back", {31'h0, tog[1]}, 0);
    rd_irq();
  endtask

  task automatic t_timeout();
    // ep2 still full from t_in_ack; toggle 0
    tok(P_IN, ADDR, 2);
    chk("R5 first pid", {28'h0, tx_pid}, P_D0);
    done_tx();
    idle(TO + 2);
    hs(P_ACK);
    chk("R5 full kept", {31'h0, full[2]}, 1);
    chk("R5 no irq", {16'h0, irq_bits}, 0);
    chk("R5 tog kept", {31'h0, tog[2]}, 0);
    tok(P_IN, ADDR, 2);
    chk("R5 resend", {28'h0, tx_pid}, P_D0);
    done_tx(); hs(P_ACK);
    rd_irq();
  endtask

  task automatic t_iso();
    wbuf(3, 1);
    tok(P_IN, ADDR, 3);
    chk("R6 data0", {28'h0, tx_pid}, P_D0);
    @(negedge clk);
    chk("R6 no early irq", {16'h0, irq_bits}, 0);
    done_tx();
    chk("R6 irq", {16'h0, irq_bits}, 16'h0008);
    chk("R6 full clr", {31'h0, full[3]}, 0);
    chk("R6 tog same", {31'h0, tog[3]}, 0);
    // R7: read on the same clock as a new set keeps the new bit
    wbuf(3, 1);
    tok(P_IN, ADDR, 3);
    @(negedge clk);
    tx_done = 1; irq_rd = 1; @(negedge clk); tx_done = 0; irq_rd = 0;
    chk("R7 set wins", {16'h0, irq_bits}, 16'h0008);
    rd_irq();
  endtask

  task automatic t_out();
    tok(P_OUT, ADDR, 4);
    chk("R8 wait", {31'h0, tx_req}, 0);
    rx();
    chk("R8 ack req", {31'h0, tx_req}, 1);
    chk("R8 ack pid", {28'h0, tx_pid}, P_ACK);
    chk("R8 full set", {31'h0, full[4]}, 1);
    chk("R8 irq", {16'h0, irq_bits}, 16'h0010);
    chk("R8 tog", {31'h0, tog[4]}, 1);
    done_tx(); rd_irq();
    tok(P_OUT, ADDR, 4); rx();
    chk("R8 nak pid", {28'h0, tx_pid}, P_NAK);
    chk("R8 nak tog", {31'h0, tog[4]}, 1);
    chk("R8 nak irq", {16'h0, irq_bits}, 0);
    done_tx();
    tok(P_OUT, ADDR, 3); rx();
    chk("R8 iso no hs", {31'h0, tx_req}, 0);
    chk("R8 iso full", {31'h0, full[3]}, 1);
    rd_irq();
  endtask

  task automatic t_out_timeout();
    tok(P_OUT, ADDR, 6);
    idle(TO + 2);
    rx();
    chk("R11 no tx", {31'h0, tx_req}, 0);
    chk("R11 no fill", {31'h0, full[6]}, 0);
  endtask

  task automatic t_cpu_buf();
    wbuf(4, 0);
    chk("R10 clear", {16'h0, full}, 16'h0008);
    wbuf(9, 1);
    chk("R10 set", {16'h0, full}, 16'h0208);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    t_reset();
    rst_n = 1;
    idle(1);
    t_ignore();
    t_in_nak();
    t_in_ack();
    t_timeout();
    t_iso();
    t_out();
    t_out_timeout();
    t_cpu_buf();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule